// File: doc/BRIEF.md
# Byte-Masked Line Merge Buffer

This block is the datapath of a single cache line. It keeps the line's bytes together with a per-byte written mask. Core stores merge into the line under their byte enables. Fill data coming back from the next level merges under the written mask, so that bytes the core has already written are never overwritten by stale fill data. A combinational flag reports whether a load's byte request is fully covered by locally written bytes. This lets a partially written line serve a load without a fetch. On request, the block also captures a write-through packet holding the full line and its written mask.

The surrounding line controller decides which states the line passes through and which operation to issue. This block only performs the merges, the coverage check and the packet capture. Every merge completes in one clock. The controller must never present a store and a fill in the same cycle.

Top module: `line_merge_buf`

## Requirements
- R1: When `st_valid_i` is high at a rising edge, each byte b whose bit `st_mask_i[b]` is 1 takes `st_data_i[8*b+7:8*b]` at that edge. Every other byte keeps its value. Byte b occupies bits 8*b+7 down to 8*b of the line, and this holds up to and including byte 63.
- R2: A store ORs `st_mask_i` into the written mask at the same edge. Bits that are already set stay set.
- R3: When `fill_valid_i` is high at a rising edge, a byte whose written-mask bit is 1 keeps its local value. Every other byte takes the matching byte of `fill_data_i`. The written mask is not changed by a fill.
- R4: `ld_cover_o` is 1 exactly when every byte set in `ld_mask_i` is also set in the current written mask. An all-zero request counts as covered. The output is combinational and needs no clock.
- R5: A cycle with `wt_req_i` high makes `wt_valid_o` 1 for the next cycle only. During that cycle, `wt_data_o` and `wt_mask_o` hold the line data and written mask as they were just before that edge, and `wt_shared_o` is 0.
- R6: `alloc_i` or `inval_i` at an edge clears the written mask to zero and leaves the line data unchanged. A store or fill in the same cycle is applied after the clear. A store then leaves the mask equal to its own byte enables, and a fill replaces every byte.
- R7: After reset, the line data, the written mask and `wt_valid_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_i | input | 1 | Line allocated: clear written mask |
| inval_i | input | 1 | Line invalidated: clear written mask |
| st_valid_i | input | 1 | Store merge strobe |
| st_data_i | input | 512 | Store data, byte b in bits 8b+7:8b |
| st_mask_i | input | 64 | Store byte enables |
| fill_valid_i | input | 1 | Fill merge strobe |
| fill_data_i | input | 512 | Fill line data |
| ld_mask_i | input | 64 | Bytes requested by a load |
| wt_req_i | input | 1 | Capture a write-through packet |
| line_data_o | output | 512 | Current line data |
| wmask_o | output | 64 | Current written mask |
| ld_cover_o | output | 1 | Load fully covered by written bytes |
| wt_valid_o | output | 1 | Write-through packet valid |
| wt_data_o | output | 512 | Write-through line data |
| wt_mask_o | output | 64 | Write-through byte mask |
| wt_shared_o | output | 1 | Write-through shared flag, always 0 |

## Verification
Two overlapping stores with distinct byte patterns show whether the merge honours each byte enable separately and whether the mask accumulates instead of being replaced. A fill over a partially written line separates a correct mask-guarded merge from a plain overwrite. The same fill after an invalidation shows that the cleared mask lets every byte through. Load requests are tried with one mask exactly covered by the written bytes, one that reaches a single byte beyond them, and one that is empty. A store to the top byte and an allocation coinciding with a store probe the edge of the byte indexing and the clear-then-merge ordering.

// File: rtl/lmb_pkg.sv
package lmb_pkg;
  localparam int unsigned LINE_BYTES = 64;
  localparam int unsigned LINE_BITS  = LINE_BYTES * 8;

  // widen a byte mask into a bit mask
  function automatic logic [LINE_BITS-1:0] expand_mask(input logic [LINE_BYTES-1:0] m);
    logic [LINE_BITS-1:0] r;
    for (int b = 0; b < LINE_BYTES; b++) r[b*8 +: 8] = {8{m[b]}};
    return r;
  endfunction

  // bytes selected by sel come from src, the rest from base
  function automatic logic [LINE_BITS-1:0] pick_bytes(input logic [LINE_BITS-1:0] base,
                                                      input logic [LINE_BITS-1:0] src,
                                                      input logic [LINE_BYTES-1:0] sel);
    logic [LINE_BITS-1:0] bm;
    bm = expand_mask(sel);
    return (src & bm) | (base & ~bm);
  endfunction

  function automatic logic mask_covers(input logic [LINE_BYTES-1:0] req,
                                       input logic [LINE_BYTES-1:0] have);
    return (req & ~have) == '0;
  endfunction
endpackage

// File: rtl/lmb_mask_track.sv
module lmb_mask_track #(
  parameter int unsigned NB = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_evt,
  input  logic          store_evt,
  input  logic [NB-1:0] st_mask,
  output logic [NB-1:0] eff_mask,
  output logic [NB-1:0] mask_q
);
  logic [NB-1:0] mask_d;

  always_comb begin
    eff_mask = clear_evt ? '0 : mask_q;
    mask_d   = eff_mask | (store_evt ? st_mask : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end
endmodule

// File: rtl/lmb_data_merge.sv
module lmb_data_merge #(
  parameter int unsigned NB = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            store_evt,
  input  logic            fill_evt,
  input  logic [NB*8-1:0] st_data,
  input  logic [NB-1:0]   st_mask,
  input  logic [NB*8-1:0] fill_data,
  input  logic [NB-1:0]   keep_mask,
  output logic [NB*8-1:0] data_q
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [7:0] nxt;
    always_comb begin
      nxt = data_q[b*8 +: 8];
      if (store_evt && st_mask[b])        nxt = st_data[b*8 +: 8];
      else if (fill_evt && !keep_mask[b]) nxt = fill_data[b*8 +: 8];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_q[b*8 +: 8] <= '0;
      else        data_q[b*8 +: 8] <= nxt;
    end
  end
endmodule

// File: rtl/lmb_wt_pack.sv
module lmb_wt_pack #(
  parameter int unsigned NB = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wt_req,
  input  logic [NB*8-1:0] line_data,
  input  logic [NB-1:0]   line_mask,
  output logic            wt_valid,
  output logic [NB*8-1:0] wt_data,
  output logic [NB-1:0]   wt_mask,
  output logic            wt_shared
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wt_valid <= 1'b0;
      wt_data  <= '0;
      wt_mask  <= '0;
    end else begin
      wt_valid <= wt_req;
      if (wt_req) begin
        wt_data <= line_data;
        wt_mask <= line_mask;
      end
    end
  end
  assign wt_shared = 1'b0;
endmodule

// File: rtl/line_merge_buf.sv
module line_merge_buf
  import lmb_pkg::*;
#(
  parameter int unsigned NB = LINE_BYTES,
  localparam int unsigned DW = NB * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_i,
  input  logic          inval_i,
  input  logic          st_valid_i,
  input  logic [DW-1:0] st_data_i,
  input  logic [NB-1:0] st_mask_i,
  input  logic          fill_valid_i,
  input  logic [DW-1:0] fill_data_i,
  input  logic [NB-1:0] ld_mask_i,
  input  logic          wt_req_i,
  output logic [DW-1:0] line_data_o,
  output logic [NB-1:0] wmask_o,
  output logic          ld_cover_o,
  output logic          wt_valid_o,
  output logic [DW-1:0] wt_data_o,
  output logic [NB-1:0] wt_mask_o,
  output logic          wt_shared_o
);
  // named events for the checker
  logic          clear_evt, store_evt, fill_evt;
  logic [NB-1:0] eff_mask;

  assign clear_evt = alloc_i | inval_i;
  assign store_evt = st_valid_i;
  assign fill_evt  = fill_valid_i;

  lmb_mask_track #(.NB(NB)) u_mask (
    .clk(clk), .rst_n(rst_n), .clear_evt(clear_evt), .store_evt(store_evt),
    .st_mask(st_mask_i), .eff_mask(eff_mask), .mask_q(wmask_o)
  );

  lmb_data_merge #(.NB(NB)) u_data (
    .clk(clk), .rst_n(rst_n), .store_evt(store_evt), .fill_evt(fill_evt),
    .st_data(st_data_i), .st_mask(st_mask_i), .fill_data(fill_data_i),
    .keep_mask(eff_mask), .data_q(line_data_o)
  );

  lmb_wt_pack #(.NB(NB)) u_wt (
    .clk(clk), .rst_n(rst_n), .wt_req(wt_req_i), .line_data(line_data_o),
    .line_mask(wmask_o), .wt_valid(wt_valid_o), .wt_data(wt_data_o),
    .wt_mask(wt_mask_o), .wt_shared(wt_shared_o)
  );

  assign ld_cover_o = mask_covers(ld_mask_i, wmask_o);
endmodule

// File: rtl/line_merge_buf_chk.sv
module line_merge_buf_chk
  import lmb_pkg::*;
#(
  parameter int unsigned NB = LINE_BYTES
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clear_evt,
  input logic            store_evt,
  input logic            fill_evt,
  input logic [NB*8-1:0] st_data_i,
  input logic [NB-1:0]   st_mask_i,
  input logic [NB*8-1:0] fill_data_i,
  input logic [NB-1:0]   ld_mask_i,
  input logic            wt_req_i,
  input logic [NB*8-1:0] line_data_o,
  input logic [NB-1:0]   wmask_o,
  input logic            ld_cover_o,
  input logic            wt_valid_o,
  input logic [NB-1:0]   wt_mask_o,
  input logic [NB*8-1:0] wt_data_o
);
  AST_NO_STORE_FILL_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_evt && fill_evt)); // R3
  AST_STORE_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    store_evt |=> ((line_data_o ^ $past(st_data_i)) & $past(expand_mask(st_mask_i))) == '0); // R1
  AST_MASK_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
    store_evt |=> (wmask_o & $past(st_mask_i)) == $past(st_mask_i)); // R2
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_evt |=> (wmask_o & $past(wmask_o)) == $past(wmask_o)); // R2
  AST_FILL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_evt && !clear_evt) |=> ((line_data_o ^ $past(line_data_o)) & $past(expand_mask(wmask_o))) == '0); // R3
  AST_FILL_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_evt && !clear_evt) |=> ((line_data_o ^ $past(fill_data_i)) & ~$past(expand_mask(wmask_o))) == '0); // R3
  AST_CLEAR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_evt && !store_evt) |=> wmask_o == '0); // R6
  AST_WT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wt_req_i |=> wt_valid_o && wt_mask_o == $past(wmask_o) && wt_data_o == $past(line_data_o)); // R5
  AST_WT_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    !wt_req_i |=> !wt_valid_o); // R5
  AST_LOAD_COVER: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cover_o |-> (ld_mask_i & ~wmask_o) == '0); // R4
endmodule

bind line_merge_buf line_merge_buf_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_evt(clear_evt), .store_evt(store_evt),
  .fill_evt(fill_evt), .st_data_i(st_data_i), .st_mask_i(st_mask_i),
  .fill_data_i(fill_data_i), .ld_mask_i(ld_mask_i), .wt_req_i(wt_req_i),
  .line_data_o(line_data_o), .wmask_o(wmask_o), .ld_cover_o(ld_cover_o),
  .wt_valid_o(wt_valid_o), .wt_mask_o(wt_mask_o), .wt_data_o(wt_data_o)
);

// File: tb/test_line_merge_buf.sv
`timescale 1ns/1ps
module test_line_merge_buf;
  localparam int NB = 64;
  localparam int DW = NB * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc_i = 0, inval_i = 0, st_valid_i = 0, fill_valid_i = 0, wt_req_i = 0;
  logic [DW-1:0] st_data_i = '0, fill_data_i = '0;
  logic [NB-1:0] st_mask_i = '0, ld_mask_i = '0;
  logic [DW-1:0] line_data_o, wt_data_o;
  logic [NB-1:0] wmask_o, wt_mask_o;
  logic          ld_cover_o, wt_valid_o, wt_shared_o;

  int n_run = 0, n_fail = 0;
  logic [DW-1:0] exp_d = '0;
  logic [NB-1:0] exp_m = '0;

  always #4 clk = ~clk;

  line_merge_buf i_line_merge_buf (.*);

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int seed);
    logic [DW-1:0] r;
    for (int b = 0; b < NB; b++) r[b*8 +: 8] = 8'((b * 7 + seed * 31 + 5) & 255);
    return r;
  endfunction

  // bench model of the byte merges
  task automatic model_store(input logic [DW-1:0] d, input logic [NB-1:0] m);
    for (int b = 0; b < NB; b++) if (m[b]) exp_d[b*8 +: 8] = d[b*8 +: 8];
    exp_m = exp_m | m;
  endtask
  task automatic model_fill(input logic [DW-1:0] d);
    for (int b = 0; b < NB; b++) if (exp_m[b] == 1'b0) exp_d[b*8 +: 8] = d[b*8 +: 8];
  endtask

  // one operation cycle: drive at negedge, release and sample at next negedge
  task automatic do_store(input logic [DW-1:0] d, input logic [NB-1:0] m, input logic clr);
    @(negedge clk);
    st_valid_i = 1; st_data_i = d; st_mask_i = m; alloc_i = clr;
    if (clr) exp_m = '0;
    model_store(d, m);
    @(negedge clk);
    st_valid_i = 0; alloc_i = 0;
  endtask
  task automatic do_fill(input logic [DW-1:0] d);
    @(negedge clk);
    fill_valid_i = 1; fill_data_i = d;
    model_fill(d);
    @(negedge clk);
    fill_valid_i = 0;
  endtask

  task automatic t_reset;
    chk("R7 data", line_data_o, '0);
    chk("R7 mask", DW'(wmask_o), '0);
    chk("R7 wt_valid", DW'(wt_valid_o), 0);
    ld_mask_i = '0; #1;
    chk("R4 empty request", DW'(ld_cover_o), 1);
  endtask

  task automatic t_stores;
    do_store(pat(1), 64'h0000_0000_0000_000F, 0);
    chk("R1 store1 data", line_data_o, exp_d);
    chk("R2 store1 mask", DW'(wmask_o), DW'(exp_m));
    do_store(pat(2), 64'h0000_0000_0000_003C, 0);
    chk("R1 store2 overlap data", line_data_o, exp_d);
    chk("R2 store2 mask accumulate", DW'(wmask_o), DW'(64'h3F));
  endtask

  task automatic t_load;
    ld_mask_i = 64'h3F; #1;
    chk("R4 exact cover", DW'(ld_cover_o), 1);
    ld_mask_i = 64'h7F; #1;
    chk("R4 one byte missing", DW'(ld_cover_o), 0);
    ld_mask_i = 64'h24; #1;
    chk("R4 sparse cover", DW'(ld_cover_o), 1);
    ld_mask_i = '0;
  endtask

  task automatic t_fill;
    do_fill(pat(9));
    chk("R3 fill keeps written bytes", line_data_o, exp_d);
    chk("R3 fill leaves mask", DW'(wmask_o), DW'(64'h3F));
  endtask

  task automatic t_wt;
    logic [DW-1:0] snap_d;
    logic [NB-1:0] snap_m;
    @(negedge clk);
    wt_req_i = 1; snap_d = exp_d; snap_m = exp_m;
    @(negedge clk);
    wt_req_i = 0;
    chk("R5 wt valid", DW'(wt_valid_o), 1);
    chk("R5 wt data", wt_data_o, snap_d);
    chk("R5 wt mask", DW'(wt_mask_o), DW'(snap_m));
    chk("R5 wt not shared", DW'(wt_shared_o), 0);
    @(negedge clk);
    chk("R5 wt one cycle", DW'(wt_valid_o), 0);
  endtask

  task automatic t_inval;
    @(negedge clk);
    inval_i = 1; exp_m = '0;
    @(negedge clk);
    inval_i = 0;
    chk("R6 inval mask", DW'(wmask_o), 0);
    chk("R6 inval data kept", line_data_o, exp_d);
    do_fill(pat(13));
    chk("R3 fill after clear", line_data_o, pat(13));
  endtask

  task automatic t_alloc_store;
    do_store(pat(20), 64'hF000_0000_0000_0100, 1);
    chk("R6 alloc+store mask", DW'(wmask_o), DW'(64'hF000_0000_0000_0100));
    chk("R6 alloc+store data", line_data_o, exp_d);
    do_store(pat(33), 64'h8000_0000_0000_0000, 0);
    chk("R1 top byte data", DW'(line_data_o[DW-1 -: 8]), DW'(pat(33) >> (DW-8)));
    chk("R1 top byte rest", line_data_o, exp_d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_stores();
    t_load();
    t_fill();
    t_wt();
    t_inval();
    t_alloc_store();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule